// File: doc/BRIEF.md
# Cumulative rank boundary decoder

This block turns a cache-line address into the DRAM rank that holds it, and into the channel when the two channels run as an interleaved pair. Software loads eight boundary bytes through a byte-wide register port, four per channel. Each byte is a running total of the memory below and including its rank. Software also loads a 3-bit page-size attribute for each rank. The lookup is purely combinational from the address, so an error pointer or a request address can be resolved in the cycle it arrives.

The block compares the two channels' boundary sets all the time. When every pair matches, the block takes the channels to be a symmetric interleaved pair. It then doubles each boundary and lets the lowest address bit pick the channel. Otherwise the block places channel 1's ranks in the address space directly above channel 0's total. A rank with no memory, or with a page-size code that is not legal, never reports a hit.

Top module: `rank_boundary_decoder`

## Requirements
- R1: After reset every boundary and attribute is zero, so `hit` is 0 and `dual` is 1.
- R2: A write with `cfg_addr[7]` choosing the channel stores `cfg_wdata` into that channel's boundary for rank k at low offset k (0 to 3). Low offset 8 holds the attributes of ranks 0 (bits 2:0) and 1 (bits 6:4). Low offset 9 holds ranks 2 (bits 2:0) and 3 (bits 6:4). Writes to any other offset change nothing.
- R3: A write changes the lookup only after the clock edge that accepts it, never in the cycle of the write itself.
- R4: A boundary byte b marks the limit b × 2^18 lines, which is b × 32 MiB of 128-byte lines. The whole byte counts, so bit 7 alone stands for 4 GiB.
- R5: In single-channel mode, ranks 0 to 3 use channel 0's limits and report `chan`=0. Ranks 4 to 7 use channel 1's limits added to channel 0's rank-3 total and report `chan`=1. The result is the lowest rank whose limit exceeds the address.
- R6: `dual` is 1 exactly when each of the four channel-0 boundaries equals the channel-1 boundary of the same rank.
- R7: In dual mode, rank r's limit is 2·b0[r] × 2^18. `rank_idx` is r in 0 to 3, `chan` equals `line_addr[0]`, and the attribute is taken from that channel.
- R8: A rank whose boundary equals the one below it owns no addresses and is never reported.
- R9: The address hits only if the attribute of the selected rank is 010, 011 or 100. The codes 000, 001, 101, 110 and 111 give `hit`=0.
- R10: An address at or above the last limit (the rank-7 limit in single mode, the rank-3 limit in dual mode) gives `hit`=0.
- R11: While `hit` is 0, `rank_idx` and `chan` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset, bit 7 selects the channel |
| cfg_wdata | input | 8 | Register write data |
| line_addr | input | 27 | Cache-line address to look up |
| hit | output | 1 | Address falls in a populated, legal rank |
| rank_idx | output | 3 | Rank holding the address |
| chan | output | 1 | Channel holding the address |
| dual | output | 1 | Channels are identically populated and interleaved |

## Verification
The lookup result is combinational, so a new `line_addr` is checked against the model in the same cycle, after the inputs have settled and before the next rising edge. A register write is due one edge later. Each write cycle is therefore checked twice: once before its edge, when the old mapping must still be in force, and once after the edge, when the new one must be. The bench drives inputs at the falling edge and samples one time unit later, so no check races the edge that commits a write.

// File: rtl/rank_boundary_decoder.sv
module rank_boundary_decoder #(
  parameter int ADDR_W      = 27,
  parameter int GRAIN_SHIFT = 25,
  parameter int LINE_SHIFT  = 7,
  parameter int RANKS       = 4,
  parameter int OFS_W       = 8,
  parameter int ATTR_BASE   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [OFS_W-1:0]                 cfg_addr,
  input  logic [7:0]                       cfg_wdata,
  input  logic [ADDR_W-1:0]                line_addr,
  output logic                             hit,
  output logic [$clog2(2*RANKS)-1:0]       rank_idx,
  output logic                             chan,
  output logic                             dual
);
  localparam int SH    = GRAIN_SHIFT - LINE_SHIFT;
  localparam int CMP_W = ADDR_W - SH + 1;
  localparam int FW    = CMP_W + SH;
  localparam int RIW   = $clog2(2*RANKS);
  localparam int LOW_W = OFS_W - 1;

  logic [1:0][RANKS-1:0][7:0] bnd;
  logic [1:0][RANKS-1:0][2:0] attr;
  logic [CMP_W-1:0] lim_s [2*RANKS];
  logic [CMP_W-1:0] lim_d [RANKS];
  logic [RANKS-1:0] eq;
  logic [FW-1:0]    addr_x;

  wire             cfg_ch  = cfg_addr[OFS_W-1];
  wire [LOW_W-1:0] cfg_low = cfg_addr[LOW_W-1:0];

  assign addr_x = FW'(line_addr);

  function automatic logic page_ok(input logic [2:0] code);
    return code inside {3'b010, 3'b011, 3'b100};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd  <= '0;
      attr <= '0;
    end else if (cfg_we) begin
      for (int r = 0; r < RANKS; r++)
        if (cfg_low == LOW_W'(r)) bnd[cfg_ch][r] <= cfg_wdata;
      for (int p = 0; p < RANKS/2; p++)
        if (cfg_low == LOW_W'(ATTR_BASE + p)) begin
          attr[cfg_ch][2*p]   <= cfg_wdata[2:0];
          attr[cfg_ch][2*p+1] <= cfg_wdata[6:4];
        end
    end
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_lim
    assign lim_s[r]       = CMP_W'(bnd[0][r]);
    assign lim_s[RANKS+r] = CMP_W'(bnd[0][RANKS-1]) + CMP_W'(bnd[1][r]);
    assign lim_d[r]       = CMP_W'(bnd[0][r]) << 1;
    assign eq[r]          = bnd[0][r] == bnd[1][r];
  end

  assign dual = &eq;

  logic           found, ok, sel_ch;
  logic [RIW-1:0] sel;

  always_comb begin
    found  = 1'b0;
    ok     = 1'b0;
    sel    = '0;
    sel_ch = 1'b0;
    if (dual) begin
      for (int r = 0; r < RANKS; r++)
        if (!found && addr_x < {lim_d[r], {SH{1'b0}}}) begin
          found  = 1'b1;
          sel    = RIW'(r);
          sel_ch = line_addr[0];
          ok     = page_ok(attr[line_addr[0]][r]);
        end
    end else begin
      for (int i = 0; i < 2*RANKS; i++)
        if (!found && addr_x < {lim_s[i], {SH{1'b0}}}) begin
          found  = 1'b1;
          sel    = RIW'(i);
          sel_ch = i >= RANKS;
          ok     = page_ok(attr[i/RANKS][i%RANKS]);
        end
    end
  end

  assign hit      = found && ok;
  assign rank_idx = hit ? sel : '0;
  assign chan     = hit && sel_ch;
endmodule

// File: rtl/rank_boundary_decoder_chk.sv
module rank_boundary_decoder_chk #(
  parameter int ADDR_W = 27,
  parameter int RANKS  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [ADDR_W-1:0]          line_addr,
  input logic                       hit,
  input logic [$clog2(2*RANKS)-1:0] rank_idx,
  input logic                       chan,
  input logic                       dual
);
  localparam int RIW = $clog2(2*RANKS);

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rank_idx == '0 && !chan)); // R11
  AST_DUAL_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && hit) |-> rank_idx < RIW'(RANKS)); // R7
  AST_DUAL_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && hit) |-> chan == line_addr[0]); // R7
  AST_SINGLE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && hit) |-> chan == (rank_idx >= RIW'(RANKS))); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_we) && $stable(line_addr)) |->
      ($stable(hit) && $stable(rank_idx) && $stable(chan) && $stable(dual))); // R3
endmodule

bind rank_boundary_decoder rank_boundary_decoder_chk #(
  .ADDR_W(ADDR_W), .RANKS(RANKS)
) u_chk (.*);

// File: tb/rank_boundary_decoder_bench.sv
module rank_boundary_decoder_bench;
  localparam int PERIOD = 10;
  localparam int G = 1 << 18;

  logic        clk = 0, rst_n = 0, cfg_we = 0;
  logic [7:0]  cfg_addr = 0, cfg_wdata = 0;
  logic [26:0] line_addr = 0;
  logic        hit, chan, dual;
  logic [2:0]  rank_idx;
  int checks = 0, errors = 0;
  int mb[2][4];
  int ma[2][4];

  always #(PERIOD/2) clk = ~clk;

  rank_boundary_decoder u_rank_boundary_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .line_addr(line_addr), .hit(hit),
    .rank_idx(rank_idx), .chan(chan), .dual(dual));

  function automatic void model(input int a, output bit eh, output int er,
                                output bit ec, output bit ed);
    bit f = 0, ok = 0;
    int lim;
    ed = 1; er = 0; ec = 0;
    for (int r = 0; r < 4; r++) if (mb[0][r] != mb[1][r]) ed = 0;
    if (ed) begin
      for (int r = 0; r < 4; r++)
        if (!f && a < 2 * mb[0][r] * G) begin
          f = 1; er = r; ec = a[0]; ok = ma[a % 2][r] inside {2, 3, 4};
        end
    end else begin
      for (int i = 0; i < 8; i++) begin
        lim = (i < 4) ? mb[0][i] : mb[0][3] + mb[1][i-4];
        if (!f && a < lim * G) begin
          f = 1; er = i; ec = (i >= 4); ok = ma[i/4][i%4] inside {2, 3, 4};
        end
      end
    end
    eh = f && ok;
    if (!eh) begin er = 0; ec = 0; end
  endfunction

  task automatic check(string tag);
    bit eh, ec, ed; int er;
    model(int'(line_addr), eh, er, ec, ed);
    checks += 4;
    if (hit !== eh) begin errors++; $display("FAIL %s hit=%0d exp=%0d addr=%0h", tag, hit, eh, line_addr); end
    if (rank_idx !== 3'(er)) begin errors++; $display("FAIL %s rank=%0d exp=%0d addr=%0h", tag, rank_idx, er, line_addr); end
    if (chan !== ec) begin errors++; $display("FAIL %s chan=%0d exp=%0d addr=%0h", tag, chan, ec, line_addr); end
    if (dual !== ed) begin errors++; $display("FAIL %s dual=%0d exp=%0d", tag, dual, ed); end
  endtask

  task automatic cyc(string tag);
    #1 check(tag);
    @(posedge clk);
    if (cfg_we) begin
      int ch = cfg_addr[7], lo = cfg_addr[6:0], d = cfg_wdata;
      if (lo < 4) mb[ch][lo] = d;
      if (lo == 8) begin ma[ch][0] = d & 7; ma[ch][1] = (d >> 4) & 7; end
      if (lo == 9) begin ma[ch][2] = d & 7; ma[ch][3] = (d >> 4) & 7; end
    end
    @(negedge clk);
    cfg_we = 0;
    #1 check(tag);
    @(negedge clk);
  endtask

  task automatic wr(input int ofs, input int d, string tag);
    cfg_we = 1; cfg_addr = 8'(ofs); cfg_wdata = 8'(d);
    cyc(tag);
  endtask

  task automatic look(input int a, string tag);
    line_addr = 27'(a);
    cyc(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    foreach (mb[c, r]) begin mb[c][r] = 0; ma[c][r] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    look(0, "R1");
    look(5 * G, "R1");
    // attributes, ch0: r0=010 r1=011 r2=000 r3=100; ch1: r0=010 r1=010 r2=001 r3=010
    wr(8'h08, 8'h32, "R2"); wr(8'h09, 8'h40, "R2");
    wr(8'h88, 8'h22, "R2"); wr(8'h89, 8'h21, "R2");
    line_addr = 0;
    wr(8'h00, 4, "R3");
    wr(8'h01, 8, "R2"); wr(8'h02, 8, "R8"); wr(8'h03, 16, "R2");
    wr(8'h80, 2, "R2"); wr(8'h81, 6, "R2"); wr(8'h82, 10, "R2"); wr(8'h83, 10, "R2");
    look(4 * G - 1, "R4"); look(4 * G, "R4"); look(8 * G, "R8");
    look(15 * G, "R5"); look(16 * G, "R5"); look(20 * G + 3, "R5");
    look(22 * G, "R9"); look(26 * G, "R10"); look(30 * G, "R10");
    wr(8'h04, 8'hFF, "R2"); wr(8'h0A, 8'h00, "R2"); wr(8'h7F, 8'h00, "R2");
    look(2 * G, "R2"); look(9 * G, "R2");
    for (int k = 0; k < 150; k++) look(int'($urandom_range(0, 32 * G)), "R5");
    wr(8'h03, 8'h80, "R4");
    look(127 * G, "R4"); look(128 * G, "R4"); look(140 * G, "R10");
    wr(8'h03, 16, "R6");
    wr(8'h80, 4, "R6"); wr(8'h81, 8, "R6"); wr(8'h82, 8, "R6");
    wr(8'h83, 16, "R6");
    look(7 * G + 1, "R7"); look(7 * G, "R7"); look(8 * G + 1, "R7");
    look(31 * G, "R7"); look(32 * G, "R10");
    wr(8'h88, 8'h30, "R9");
    look(3, "R9"); look(4, "R9");
    for (int k = 0; k < 150; k++) look(int'($urandom_range(0, 34 * G)), "R7");
    wr(8'h82, 9, "R6");
    look(7 * G, "R6");
    for (int k = 0; k < 100; k++) look(int'($urandom_range(0, 40 * G)), "R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule